// File: doc/BRIEF.md
# Video Frame Sequencer with Debug Suspend

This block is the per-channel frame controller of a video output path. On every vertical sync pulse it decides whether a new frame starts. When one starts, it hands a frame start address and a one-cycle frame-go strobe to the memory fetch engine. When a frame finishes, it raises a one-cycle frame-done interrupt. Software sets the start address and an enable bit through a simple write port. These writes land in a shadow bank. The shadow bank is copied into the active bank only at vertical sync, so a frame never sees a half-written configuration.

A debug-suspend input lets a halted processor keep the picture on screen. The frame that is running when suspend arrives always completes and reports its interrupt. After that, the block masks interrupts and re-issues the same frame at every sync. Writes made in the meantime stay in the shadow bank. The first sync after suspend is released loads them and brings interrupts back. Stopping is always soft: clearing enable only prevents the next frame from starting.

Top module: `video_frame_seq`

## Requirements
- R1: After reset, frame_go_o and frame_irq_o are low and frame_addr_o is zero.
- R2: A write with wr_sel_i = 1 sets the enable shadow from wr_data_i bit 0, and a write with wr_sel_i = 0 sets the start-address shadow. While idle, a vsync with enable set pulses frame_go_o for one cycle, starting the cycle after vsync_i is sampled; a vsync with enable clear gives no strobe.
- R3: The first frame after idle raises no frame-done interrupt.
- R4: While not suspended, each vsync copies the shadow bank to the active bank, so frame_addr_o shows the latest written address together with that sync's frame_go_o.
- R5: Writes made while suspend is asserted do not change frame_addr_o or the enable in use.
- R6: When suspend is asserted during a frame, the next vsync still pulses frame_irq_o for the completed frame and starts a replay at the unchanged address.
- R7: At every further vsync while suspend stays asserted, frame_irq_o stays low and frame_go_o replays the same address, even if enable was cleared during suspend.
- R8: At the first vsync after suspend is released, the shadow bank is loaded, frame_irq_o pulses, and frame_go_o starts the new address.
- R9: A suspend pulse that starts and ends inside one frame has no effect: the next vsync behaves as a normal one.
- R10: After enable is cleared, the next vsync pulses frame_irq_o for the finished frame but gives no frame_go_o; the vsyncs that follow give neither.
- R11: While idle and suspended, a vsync starts no frame. The first vsync after release starts it, without an interrupt.
- R12: frame_go_o and frame_irq_o never go high except in the cycle right after vsync_i is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync_i | input | 1 | One-cycle vertical sync pulse |
| suspend_i | input | 1 | Debug suspend request, level |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | REG_AW | Register index: 0 start address, 1 control |
| wr_data_i | input | ADDR_W | Write data; control uses bit 0 as enable |
| frame_go_o | output | 1 | One-cycle frame start strobe |
| frame_addr_o | output | ADDR_W | Active frame start address |
| frame_irq_o | output | 1 | One-cycle frame-done interrupt |

## Verification
The assertions assume that vsync_i is a single-cycle pulse and that suspend_i changes at least one cycle away from a vsync. A change on the sync edge itself would be sampled one cycle late, and the checks do not cover that case. The assertions also assume that register writes do not fall on the same cycle as a vsync. The directed stimulus keeps to these assumptions: it changes suspend and writes registers a few cycles inside each frame, and it spaces the sync pulses well apart.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_RUN     = 2'd1,
      ST_PENDING = 2'd2,
      ST_HELD    = 2'd3
   } seq_state_e;

   localparam int unsigned SEL_ADDR = 0;
   localparam int unsigned SEL_CTRL = 1;
endpackage

// File: rtl/vfs_sus_sample.sv
module vfs_sus_sample #(
   parameter int unsigned STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sus_i,
   output logic sus_q
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("vfs_sus_sample: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) sus_q <= 1'b0;
            else        sus_q <= sus_i;
         end
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], sus_i};
         end
         assign sus_q = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/vfs_regs.sv
module vfs_regs
   import vfs_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned REG_AW     = 2,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              load,
   output logic              sh_en,
   output logic [ADDR_W-1:0] act_addr,
   output logic              act_en
);
   localparam logic [REG_AW-1:0] IDX_ADDR = REG_AW'(SEL_ADDR);
   localparam logic [REG_AW-1:0] IDX_CTRL = REG_AW'(SEL_CTRL);

   logic [ADDR_W-1:0] sh_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_addr <= RESET_ADDR;
         sh_en   <= 1'b0;
      end else if (wr_en) begin
         if (wr_sel == IDX_ADDR) sh_addr <= wr_data;
         if (wr_sel == IDX_CTRL) sh_en   <= wr_data[0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_addr <= RESET_ADDR;
         act_en   <= 1'b0;
      end else if (load) begin
         act_addr <= sh_addr;
         act_en   <= sh_en;
      end
   end

   // R5: active bank moves only on a load strobe from the controller
   p_active_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(act_addr) && $stable(act_en)));
endmodule

// File: rtl/vfs_ctrl.sv
module vfs_ctrl
   import vfs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic vsync,
   input  logic sus_q,
   input  logic sh_en,
   output logic load,
   output logic go_q,
   output logic irq_q
);
   seq_state_e state_q, state_d;
   logic       rel_q, rel_d;
   logic       go_d, irq_d;

   always_comb begin
      state_d = state_q;
      load    = 1'b0;
      go_d    = 1'b0;
      irq_d   = 1'b0;
      rel_d   = rel_q;
      unique case (state_q)
         ST_IDLE: begin
            if (vsync && !sus_q) begin
               load    = 1'b1;
               go_d    = sh_en;
               state_d = sh_en ? ST_RUN : ST_IDLE;
            end
         end
         ST_RUN, ST_PENDING: begin
            if (vsync) begin
               irq_d = 1'b1;
               if (sus_q) begin
                  go_d    = 1'b1;
                  state_d = ST_HELD;
                  rel_d   = 1'b0;
               end else begin
                  load    = 1'b1;
                  go_d    = sh_en;
                  state_d = sh_en ? ST_RUN : ST_IDLE;
               end
            end else begin
               state_d = sus_q ? ST_PENDING : ST_RUN;
            end
         end
         ST_HELD: begin
            if (vsync) begin
               rel_d = 1'b0;
               if (rel_q || !sus_q) begin
                  irq_d   = 1'b1;
                  load    = 1'b1;
                  go_d    = sh_en;
                  state_d = sh_en ? ST_RUN : ST_IDLE;
               end else begin
                  go_d = 1'b1;
               end
            end else begin
               rel_d = !sus_q;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rel_q   <= 1'b0;
         go_q    <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         rel_q   <= rel_d;
         go_q    <= go_d;
         irq_q   <= irq_d;
      end
   end

   // R12: strobes only follow a sampled sync
   p_go_after_sync_r12: assert property (@(posedge clk) disable iff (!rst_n)
      go_q |-> $past(vsync));
   p_irq_after_sync_r12: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(vsync));
   // R7: held with suspend still up masks the interrupt
   p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HELD && !rel_q && sus_q && vsync) |=> (!irq_q && go_q));
   // R3: leaving idle never reports a frame
   p_idle_no_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && vsync) |=> !irq_q);
endmodule

// File: rtl/video_frame_seq.sv
module video_frame_seq
   import vfs_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned REG_AW     = 2,
   parameter int unsigned SUS_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vsync_i,
   input  logic              suspend_i,
   input  logic              wr_en_i,
   input  logic [REG_AW-1:0] wr_sel_i,
   input  logic [ADDR_W-1:0] wr_data_i,
   output logic              frame_go_o,
   output logic [ADDR_W-1:0] frame_addr_o,
   output logic              frame_irq_o
);
   generate
      if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr_w
         $error("video_frame_seq: ADDR_W must be 8..64");
      end
      if (REG_AW < 1) begin : g_bad_reg_aw
         $error("video_frame_seq: REG_AW must be at least 1");
      end
   endgenerate

   logic sus_q, sh_en, act_en, load;

   vfs_sus_sample #(.STAGES(SUS_STAGES)) u_sus (
      .clk   (clk),
      .rst_n (rst_n),
      .sus_i (suspend_i),
      .sus_q (sus_q)
   );

   vfs_regs #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en_i),
      .wr_sel   (wr_sel_i),
      .wr_data  (wr_data_i),
      .load     (load),
      .sh_en    (sh_en),
      .act_addr (frame_addr_o),
      .act_en   (act_en)
   );

   vfs_ctrl u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .vsync (vsync_i),
      .sus_q (sus_q),
      .sh_en (sh_en),
      .load  (load),
      .go_q  (frame_go_o),
      .irq_q (frame_irq_o)
   );

   // R4: a start that came with a load uses the enable just made active
   p_go_matches_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(load) && frame_go_o) |-> act_en);
   // R6: a replay start (no load) keeps the address of the previous cycle
   p_replay_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_go_o && !$past(load)) |-> $stable(frame_addr_o));
endmodule

// File: tb/sim_video_frame_seq.sv
module sim_video_frame_seq;
   localparam int CLK_P  = 10;
   localparam int ADDR_W = 32;
   localparam int REG_AW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vsync_i = 1'b0, suspend_i = 1'b0, wr_en_i = 1'b0;
   logic [REG_AW-1:0] wr_sel_i = '0;
   logic [ADDR_W-1:0] wr_data_i = '0;
   logic frame_go_o, frame_irq_o;
   logic [ADDR_W-1:0] frame_addr_o;

   int checks = 0, fails = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   video_frame_seq #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u0 (.*);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [REG_AW-1:0] sel, input logic [ADDR_W-1:0] d);
      @(negedge clk); wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
      @(negedge clk); wr_en_i = 1'b0;
   endtask

   task automatic set_sus(input logic v);
      @(negedge clk); suspend_i = v;
      idle(3);
   endtask

   // sync pulse, then compare the strobes seen in the following cycle
   task automatic sync_chk(input string req, input logic eg, input logic ei,
                           input logic [ADDR_W-1:0] ea, input bit cka);
      @(negedge clk); vsync_i = 1'b1;
      @(negedge clk); vsync_i = 1'b0;
      chk({req, " go"}, frame_go_o, eg);
      chk({req, " irq"}, frame_irq_o, ei);
      if (cka) chk({req, " addr"}, frame_addr_o, ea);
      @(negedge clk);
      chk({req, " go width"}, frame_go_o, 1'b0);
      chk({req, " irq width"}, frame_irq_o, 1'b0);
      idle(6);
   endtask

   task automatic t_reset();   // R1
      chk("R1 go", frame_go_o, 0);
      chk("R1 irq", frame_irq_o, 0);
      chk("R1 addr", frame_addr_o, 0);
   endtask

   task automatic t_start();   // R2 R3
      sync_chk("R2 no enable", 0, 0, 0, 1);
      wr(0, 32'h0000_1000);
      wr(1, 32'h1);
      sync_chk("R3 first frame", 1, 0, 32'h1000, 1);
   endtask

   task automatic t_normal();  // R4
      wr(0, 32'h0000_2000);
      sync_chk("R4 shadow copy", 1, 1, 32'h2000, 1);
      wr(2, 32'h0000_7777);
      sync_chk("R4 unused index", 1, 1, 32'h2000, 1);
   endtask

   task automatic t_suspend(); // R5 R6 R7 R8
      set_sus(1);
      wr(0, 32'h0000_3000);
      sync_chk("R6 finish frame", 1, 1, 32'h2000, 1);
      sync_chk("R7 replay", 1, 0, 32'h2000, 1);
      wr(1, 32'h0);
      sync_chk("R5 latent disable", 1, 0, 32'h2000, 1);
      wr(1, 32'h1);
      sync_chk("R7 replay again", 1, 0, 32'h2000, 1);
      set_sus(0);
      sync_chk("R8 release", 1, 1, 32'h3000, 1);
      sync_chk("R8 normal after", 1, 1, 32'h3000, 1);
   endtask

   task automatic t_glitch();  // R9
      wr(0, 32'h0000_4000);
      set_sus(1);
      set_sus(0);
      sync_chk("R9 short suspend", 1, 1, 32'h4000, 1);
   endtask

   task automatic t_stop();    // R10
      wr(1, 32'h0);
      sync_chk("R10 last irq", 0, 1, 0, 0);
      sync_chk("R10 stopped", 0, 0, 0, 0);
   endtask

   task automatic t_idle_sus(); // R11
      wr(0, 32'h0000_5000);
      wr(1, 32'h1);
      set_sus(1);
      sync_chk("R11 held idle", 0, 0, 32'h4000, 1);
      set_sus(0);
      sync_chk("R11 start after release", 1, 0, 32'h5000, 1);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      t_reset();
      @(negedge clk); rst_n = 1'b1;
      idle(2);
      t_reset();
      t_start();
      t_normal();
      t_suspend();
      t_glitch();
      t_stop();
      t_idle_sus();
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule